// File: doc/BRIEF.md
# Three-Lane Seven-to-One Serial Transmitter

This block turns a 21-bit parallel word into three serial data lanes and one forwarded clock lane. A word is captured on every rising edge of a slow word clock. Each lane then sends 7 bits of that word, one bit per cycle of a bit clock running at exactly seven times the word rate. At a 75 MHz word rate each lane carries 525 Mb/s. The supported word-rate range is 15 to 75 MHz. The bit clock comes from an external multiplier and is an input here. The differential drivers sit outside the block and use the output-enable signal to tristate the lines.

The fourth lane repeats a fixed seven-slot pattern: high for four slots, then low for three. It is aligned so that its rising edge marks the slot carrying the first bit of each word. The receiver uses that edge to find word boundaries.

An active-low power-down input disables all outputs. While the outputs are disabled, the serial lines are held low. After power-down is released, or after reset, the block waits a parameterised number of word periods. This gives the external clock multiplier time to settle. The outputs are then re-enabled at the start of a frame.

Top module: `tx7_serializer`

## Requirements
- R1: The 21-bit input is captured on the rising edge of the word clock. A change of the input between rising edges (the bench changes it on the falling edge) has no effect on the frame being sent.
- R2: Serial lane k (k = 0, 1, 2) carries input bits 7k+6 down to 7k. Lane 0 carries bits 6..0, lane 1 carries bits 13..7 and lane 2 carries bits 20..14.
- R3: Within a lane, the highest-numbered bit of the group is sent first and the lowest-numbered bit last. Each bit lasts one bit-clock cycle, so a frame is seven bit-clock cycles.
- R4: The clock lane shows 1,1,1,1,0,0,0 across the seven slots of a frame. Its rising edge coincides with the first data slot.
- R5: The first slot of a frame appears on the third rising bit-clock edge after the word-clock rising edge that captured the word. Two of those edges are spent synchronising the word clock.
- R6: When the power-down input is low, out_en falls and all four serial outputs are held low. This happens no later than the third rising bit-clock edge after the input falls, and the outputs stay low while the input stays low.
- R7: After power-down is released, or after reset, out_en stays low for LOCK_WORDS frame starts. It rises on the frame start that follows them. In the bench, with LOCK_WORDS = 3, out_en is high after the 4th word-clock rising edge that follows the release, and low after the 3rd.
- R8: While reset is high and just after it, out_en is low and all serial outputs are low.
- R9: out_en rises only on a frame start, so the first enabled frame is always complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, bit-clock domain |
| bit_clk | input | 1 | Bit clock, seven times the word rate |
| word_clk | input | 1 | Word clock; its rising edge captures par_in |
| pd_n | input | 1 | Power-down, active low, asynchronous to bit_clk |
| par_in | input | 21 | Parallel word |
| ser_data | output | 3 | Serial data lanes, bit k is lane k |
| ser_clk | output | 1 | Forwarded clock lane |
| out_en | output | 1 | High when the line drivers may drive; low tristates them |

## Verification
Two events can fall on the same cycle: the lock wait expiring, and a frame load. The enable is supposed to rise exactly on that load. The bench releases power-down in the middle of a word and counts word-clock edges to check that the enable rises on the expected frame. It also checks that the frame opened by the enable is complete and correct. The second collision is a power-down that lands while a frame is shifting: the bench drops pd_n at a random bit offset, then checks that the lanes go quiet within the stated bound and that no partial frame is reported as a word.

// File: rtl/tx7_pkg.sv
`timescale 1ns/1ps
package tx7_pkg;
  localparam int LANES     = 3;
  localparam int SLOTS     = 7;
  localparam int WORD_W    = LANES * SLOTS;
  localparam int CLK_HIGH  = 4;
  localparam int SLOT_W    = $clog2(SLOTS);
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/tx7_frame_timer.sv
`timescale 1ns/1ps
module tx7_frame_timer
  import tx7_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  word_clk,
  output logic  load,
  output slot_t slot,
  output logic  clk_lane
);
  logic  wck_m, wck_q, wck_qq;
  slot_t slot_nx;

  assign load = wck_q & ~wck_qq;

  always_comb begin
    if (load)                          slot_nx = '0;
    else if (slot == slot_t'(SLOTS-1)) slot_nx = slot;
    else                               slot_nx = slot + slot_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wck_m    <= 1'b0;
      wck_q    <= 1'b0;
      wck_qq   <= 1'b0;
      slot     <= slot_t'(SLOTS-1);
      clk_lane <= 1'b0;
    end else begin
      wck_m    <= word_clk;
      wck_q    <= wck_m;
      wck_qq   <= wck_q;
      slot     <= slot_nx;
      clk_lane <= (slot_nx < slot_t'(CLK_HIGH));
    end
  end

  // R4: the clock lane rises only in the first slot of a frame
  p_clk_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_lane) |-> slot == '0);
  // R5: a frame start is a single-cycle event
  p_load_single_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);
endmodule

// File: rtl/tx7_lane.sv
`timescale 1ns/1ps
module tx7_lane #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] group,
  output logic         sout
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      sout <= 1'b0;
    end else if (load) begin
      sr   <= {group[W-2:0], 1'b0};
      sout <= group[W-1];
    end else begin
      sr   <= {sr[W-2:0], 1'b0};
      sout <= sr[W-1];
    end
  end

  // R3: the highest-numbered bit of the group leads the frame
  p_first_bit_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> sout == $past(group[W-1]));
endmodule

// File: rtl/tx7_power_ctl.sv
`timescale 1ns/1ps
module tx7_power_ctl #(
  parameter int LOCK_WORDS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  input  logic load,
  output logic oe
);
  localparam int CW = $clog2(LOCK_WORDS + 2);
  logic          pd_m, pd_s;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_m <= 1'b0;
      pd_s <= 1'b0;
      cnt  <= '0;
      oe   <= 1'b0;
    end else begin
      pd_m <= pd_n;
      pd_s <= pd_m;
      if (!pd_s) begin
        oe  <= 1'b0;
        cnt <= '0;
      end else if (!oe && load) begin
        if (cnt == CW'(LOCK_WORDS)) oe  <= 1'b1;
        else                        cnt <= cnt + CW'(1);
      end
    end
  end

  // R6: a synchronised power-down forces the enable low on the next edge
  p_pd_off_r6: assert property (@(posedge clk) disable iff (rst)
    !pd_s |=> !oe);
  // R7: the lock counter never passes its limit
  p_lock_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LOCK_WORDS));
  // R9: the enable rises only on a frame start
  p_rise_on_load_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(load));
endmodule

// File: rtl/tx7_serializer.sv
`timescale 1ns/1ps
module tx7_serializer
  import tx7_pkg::*;
#(
  parameter int LOCK_WORDS = 16
) (
  input  logic              rst,
  input  logic              bit_clk,
  input  logic              word_clk,
  input  logic              pd_n,
  input  logic [WORD_W-1:0] par_in,
  output logic [LANES-1:0]  ser_data,
  output logic              ser_clk,
  output logic              out_en
);
  logic [WORD_W-1:0] cap_q;
  logic              load, clk_lane, oe;
  logic [LANES-1:0]  lane_bit;
  slot_t             slot;

  // word-clock domain capture; held stable for a whole word period
  always_ff @(posedge word_clk) cap_q <= par_in;

  tx7_frame_timer u_timer (
    .clk(bit_clk), .rst(rst), .word_clk(word_clk),
    .load(load), .slot(slot), .clk_lane(clk_lane)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tx7_lane #(.W(SLOTS)) u_lane (
      .clk(bit_clk), .rst(rst), .load(load),
      .group(cap_q[k*SLOTS +: SLOTS]), .sout(lane_bit[k])
    );
  end

  tx7_power_ctl #(.LOCK_WORDS(LOCK_WORDS)) u_pwr (
    .clk(bit_clk), .rst(rst), .pd_n(pd_n), .load(load), .oe(oe)
  );

  assign ser_data = lane_bit & {LANES{oe}};
  assign ser_clk  = clk_lane & oe;
  assign out_en   = oe;

  // R9: when enabled the frame slot counter is at the first slot
  p_en_frame_r9: assert property (@(posedge bit_clk) disable iff (rst)
    $rose(out_en) |-> slot == '0);
endmodule

// File: tb/sim_tx7_serializer.sv
`timescale 1ns/1ps
module sim_tx7_serializer;
  localparam int LOCK = 3;

  logic        rst, bit_clk, word_clk, pd_n;
  logic [20:0] par_in;
  logic [2:0]  ser_data;
  logic        ser_clk, out_en;

  int n_chk = 0, n_bad = 0, frames = 0, edges_since = 0, widx = 0;
  logic [20:0] last_word = '0;

  tx7_serializer #(.LOCK_WORDS(LOCK)) u0 (
    .rst(rst), .bit_clk(bit_clk), .word_clk(word_clk), .pd_n(pd_n),
    .par_in(par_in), .ser_data(ser_data), .ser_clk(ser_clk), .out_en(out_en)
  );

  initial begin bit_clk = 0; forever #4 bit_clk = ~bit_clk; end
  initial begin
    word_clk = 0; #58;
    forever begin word_clk = 1; #28; word_clk = 0; #28; end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [20:0] pick_word(input int i);
    case (i)
      0: return 21'h000000;
      1: return 21'h1FFFFF;
      2: return 21'h000040;
      3: return 21'h002000;
      4: return 21'h100000;
      5: return 21'h000001;
      6: return 21'h155555;
      7: return 21'h0AAAAA;
      default: return 21'($urandom);
    endcase
  endfunction

  function automatic logic [6:0] clk_pattern();
    logic [6:0] p;
    for (int j = 0; j < 7; j++) p[6-j] = (j < 4);
    return p;
  endfunction

  always @(posedge word_clk) begin last_word = par_in; edges_since = 0; end
  always @(posedge bit_clk) edges_since++;
  always @(negedge word_clk) begin par_in = pick_word(widx); widx++; end

  // frame receiver
  logic        busy = 0, prev_clk = 0;
  int          idx = 0;
  logic [20:0] fexp, got;
  logic [6:0]  gclk;
  always @(negedge bit_clk) begin
    if (!out_en) busy = 0;
    else if (!busy && ser_clk && !prev_clk) begin
      busy = 1; idx = 0; fexp = last_word; got = '0; gclk = '0;
      chk(edges_since == 3, "R5 frame start edge count", edges_since, 3);
    end
    if (busy) begin
      for (int k = 0; k < 3; k++) got[k*7 + 6 - idx] = ser_data[k];
      gclk[6-idx] = ser_clk;
      idx++;
      if (idx == 7) begin
        chk(got == fexp, "R1/R2/R3 lane word", 32'(got), 32'(fexp));
        chk(gclk == clk_pattern(), "R4 clock lane pattern", 32'(gclk), 32'(clk_pattern()));
        frames++; busy = 0;
      end
    end
    prev_clk = ser_clk;
  end

  task automatic lock_check(input string what);
    for (int k = 1; k <= LOCK + 2; k++) begin
      @(posedge word_clk); #20;
      chk(out_en == (k >= LOCK + 1), what, out_en, (k >= LOCK + 1));
    end
  endtask

  task automatic pd_pulse(input int off);
    bit quiet = 1;
    repeat (off) @(negedge bit_clk);
    pd_n = 0;
    repeat (3) @(negedge bit_clk);
    chk(!out_en && ser_data == 0 && !ser_clk, "R6 disable bound", {out_en, ser_clk, ser_data}, 0);
    repeat (20) begin
      @(negedge bit_clk);
      if (out_en || ser_data != 0 || ser_clk) quiet = 0;
    end
    chk(quiet, "R6 stays quiet while down", quiet, 1);
    @(negedge word_clk); pd_n = 1;
    lock_check("R7/R9 enable after release");
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst = 1; pd_n = 1; par_in = '0;
    repeat (5) @(negedge bit_clk);
    chk(!out_en && ser_data == 0 && !ser_clk, "R8 reset state", {out_en, ser_clk, ser_data}, 0);
    @(negedge word_clk); rst = 0;
    @(negedge bit_clk);
    chk(!out_en && ser_data == 0, "R8 just after reset", {out_en, ser_data}, 0);
    lock_check("R7 lock wait after reset");
    repeat (40) @(posedge word_clk);
    for (int p = 0; p < 3; p++) begin
      pd_pulse($urandom_range(0, 20));
      repeat (15) @(posedge word_clk);
    end
    @(negedge bit_clk);
    chk(frames > 50, "R2 enough frames received", frames, 50);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule